// File: doc/BRIEF.md
# DMA Channel with Address Hold

This block is a single-channel transfer sequencer. Software programs a source address, a destination address, a byte count and a mode word through a register write port. The channel then copies the bytes over a simple request/acknowledge memory port. Each beat is one read followed by one write of 1, 2, 4 or 8 bytes.

Either address can be held fixed for the whole job, so that a peripheral data port behaving like a FIFO can be drained or filled. Each held side has its own access size.

A job starts in one of two ways: a start bit in the mode word, or the single-write mode, where a write to one chosen address register starts the job. Before any memory request, a check at start time rejects inconsistent programming. The channel keeps done, programming-error and transfer-error flags, which software clears by writing 1 to them. A single interrupt line follows the enabled flags.

Top module: `dma_hold_chan`

## Requirements
- R1: After reset the channel is idle: busy, mem_req, all three status flags and irq are low.
- R2: With no hold, the channel moves the programmed byte count from source to destination. Each beat's size is the largest power of two that is no larger than the bandwidth size (mode bits 8:7) and no larger than the remaining count. Both addresses advance by the bytes moved. The size code on mem_size is 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes.
- R3: With source hold (mode bit 1), every read uses the programmed source address and the source hold size (mode bits 4:3). The destination still advances.
- R4: With destination hold (mode bit 2), every write uses the programmed destination address and the destination hold size (mode bits 6:5). After the job, the destination holds the last beat's bytes.
- R5: Each of these is a programming error: a zero byte count, a count that is not a multiple of a held side's size, or a held address that is not aligned to its size. On a programming error the channel sets the programming-error flag and issues no memory request.
- R6: Two more settings are programming errors, with the same outcome as R5: a hold size larger than the bandwidth size, and both sides held with different sizes.
- R7: Writing the mode register (reg_addr 0) with bit 0 set starts a job. While the channel is busy, every write to the mode, source, destination and count registers is ignored, including any start.
- R8: Single-write start depends on mode bits 9 and 10. With bit 9 set and bit 10 set, a write to the source register (reg_addr 2) starts the job. With bit 9 set and bit 10 clear, a write to the destination register (reg_addr 3) starts the job. With bit 9 clear, neither write starts a job. The count register is at reg_addr 4.
- R9: When a job completes, the done flag is set. irq is raised if the done interrupt enable (mode bit 11) is set.
- R10: An error response (mem_err with mem_ack) stops the job and sets the transfer-error flag, without setting done. An error flag raises irq only when the error interrupt enable (mode bit 12) is set; otherwise the error is only recorded.
- R11: The status register (reg_addr 1) holds done in bit 0, programming error in bit 1 and transfer error in bit 2. Writing 1 to a bit clears that flag. A flag, and the irq it drives, stays set until it is cleared this way.
- R12: Once raised, mem_req, mem_we and mem_addr hold steady until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | 64 | Write data, least significant byte first |
| mem_rdata | input | 64 | Read data, least significant byte first |
| mem_ack | input | 1 | Access accepted and completed |
| mem_err | input | 1 | Error response, valid with mem_ack |
| busy | output | 1 | A job or its closing step is in progress |
| stat_done | output | 1 | Done flag |
| stat_perr | output | 1 | Programming-error flag |
| stat_xerr | output | 1 | Transfer-error flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the channel with ADDR_W = 16 and CNT_W = 10. With these values, a 256-byte memory model on the low address byte covers every job, with source and destination regions kept apart. It sweeps counts from 1 to 19 under all four bandwidth sizes, every hold size with several multiples on each side, and both-side hold. Each job's full beat sequence and final memory are checked against an arithmetic model in the bench. A programmable response delay and an error injected at a chosen access make the busy-write window and the transfer-error path reachable.

// File: rtl/dma_hold_pkg.sv
// Package dma_hold_pkg
// Shared types and helpers for the address-hold DMA channel.
// Assumes a 64-bit data path, so the access size code tops out at 8 bytes.
package dma_hold_pkg;

    localparam logic [2:0] REG_MODE = 3'd0;
    localparam logic [2:0] REG_STAT = 3'd1;
    localparam logic [2:0] REG_SRC  = 3'd2;
    localparam logic [2:0] REG_DST  = 3'd3;
    localparam logic [2:0] REG_CNT  = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_WRITE = 3'd2,
        ST_DONE  = 3'd3,
        ST_ERROR = 3'd4
    } chan_state_t;

    // Mode word bits 12:1, most significant field first.
    typedef struct packed {
        logic       err_ie;
        logic       done_ie;
        logic       start_sel_src;
        logic       single_wr;
        logic [1:0] bw_sz;
        logic [1:0] dst_sz;
        logic [1:0] src_sz;
        logic       hold_dst;
        logic       hold_src;
    } mode_t;

    // Byte count for a size code.
    function automatic logic [3:0] sz_bytes(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

    // Largest size code that fits in 'room' bytes, capped at 'cap'.
    function automatic logic [1:0] fit_code(input logic [1:0] cap, input logic [3:0] room);
        logic [1:0] c;
        if (room >= 4'd8)      c = 2'd3;
        else if (room >= 4'd4) c = 2'd2;
        else if (room >= 4'd2) c = 2'd1;
        else                   c = 2'd0;
        return (c < cap) ? c : cap;
    endfunction

endpackage

// File: rtl/dma_hold_regs.sv
// Module dma_hold_regs
// Configuration registers and start detection.
// Writes to mode/source/destination/count are dropped while busy.
// A start (mode bit 0, or a single-write start) gives a one-cycle
// registered pulse; the status write turns into a one-cycle clear vector.
module dma_hold_regs
    import dma_hold_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              busy,
    output mode_t             mode_q,
    output logic [ADDR_W-1:0] src_q,
    output logic [ADDR_W-1:0] dst_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              start_p,
    output logic [2:0]        stat_clr
);

    logic cfg_we;
    assign cfg_we = reg_we && !busy;

    // Configuration storage and start pulse generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            cnt_q   <= '0;
            start_p <= 1'b0;
        end else begin
            start_p <= 1'b0;
            if (cfg_we) begin
                unique case (reg_addr)
                    REG_MODE: begin
                        mode_q  <= mode_t'(reg_wdata[12:1]);
                        start_p <= reg_wdata[0];
                    end
                    REG_SRC: begin
                        src_q   <= reg_wdata[ADDR_W-1:0];
                        start_p <= mode_q.single_wr && mode_q.start_sel_src;
                    end
                    REG_DST: begin
                        dst_q   <= reg_wdata[ADDR_W-1:0];
                        start_p <= mode_q.single_wr && !mode_q.start_sel_src;
                    end
                    REG_CNT: cnt_q <= reg_wdata[CNT_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    // Write-one-to-clear vector for the status flags.
    always_comb begin
        stat_clr = '0;
        if (reg_we && reg_addr == REG_STAT) stat_clr = reg_wdata[2:0];
    end

    // R7: configuration cannot change while a job runs.
    a_r7_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(src_q) && $stable(dst_q) && $stable(cnt_q) && $stable(mode_q)));

endmodule

// File: rtl/dma_hold_check.sv
// Module dma_hold_check
// Start-time programming check, purely combinational.
// Flags a zero count, a held side whose count or address is not a
// multiple of its size, a hold size above the bandwidth size, and
// two held sides with different sizes.
module dma_hold_check
    import dma_hold_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  mode_t             mode,
    input  logic [ADDR_W-1:0] src,
    input  logic [ADDR_W-1:0] dst,
    input  logic [CNT_W-1:0]  cnt,
    output logic              prog_err
);

    logic [1:0] side_bad;

    logic unused_mode;
    assign unused_mode = ^{mode.err_ie, mode.done_ie, mode.start_sel_src, mode.single_wr};

    // One identical rule set per side: 0 = source, 1 = destination.
    for (genvar g = 0; g < 2; g++) begin : g_side
        logic              hold;
        logic [1:0]        sz;
        logic [ADDR_W-1:0] addr;
        logic [3:0]        mask;
        assign hold = (g == 0) ? mode.hold_src : mode.hold_dst;
        assign sz   = (g == 0) ? mode.src_sz   : mode.dst_sz;
        assign addr = (g == 0) ? src           : dst;
        assign mask = sz_bytes(sz) - 4'd1;
        assign side_bad[g] = hold && (((cnt & CNT_W'(mask)) != '0) ||
                                      ((addr & ADDR_W'(mask)) != '0) ||
                                      (sz > mode.bw_sz));
    end

    // Combine the per-side results with the count and size-mismatch rules.
    always_comb begin
        prog_err = (cnt == '0) || (|side_bad) ||
                   (mode.hold_src && mode.hold_dst && (mode.src_sz != mode.dst_sz));
    end

endmodule

// File: rtl/dma_hold_engine.sv
// Module dma_hold_engine
// Transfer state machine: one read, then one write per beat, through a
// single-beat data register. The job settings are latched at start so
// that later register traffic cannot affect a running job.
// Assumes the memory keeps mem_ack low unless a request is pending.
module dma_hold_engine
    import dma_hold_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_t             mode,
    input  logic [ADDR_W-1:0] src,
    input  logic [ADDR_W-1:0] dst,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              start_p,
    input  logic              prog_err,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    output logic              busy,
    output logic              done_p,
    output logic              perr_p,
    output logic              xerr_p
);

    chan_state_t       state;
    logic              hs_q, hd_q, prog_kind;
    logic [1:0]        ssz_q, dsz_q, bw_q, beat_q, beat_rd;
    logic [ADDR_W-1:0] src_base_q, dst_base_q, cur_src, cur_dst, step_a;
    logic [CNT_W-1:0]  remain, beat_bytes;
    logic [3:0]        room;
    logic [DATA_W-1:0] data_q;

    logic unused_mode;
    assign unused_mode = ^{mode.err_ie, mode.done_ie, mode.start_sel_src, mode.single_wr};

    // Size of the next read: a held side's size, else the fitted size.
    always_comb begin
        room = (remain >= CNT_W'(8)) ? 4'd8 : remain[3:0];
        if (hs_q)      beat_rd = ssz_q;
        else if (hd_q) beat_rd = dsz_q;
        else           beat_rd = fit_code(bw_q, room);
        beat_bytes = CNT_W'(sz_bytes(beat_q));
        step_a     = ADDR_W'(sz_bytes(beat_q));
    end

    // Memory port outputs follow the state.
    always_comb begin
        mem_req   = (state == ST_READ) || (state == ST_WRITE);
        mem_we    = (state == ST_WRITE);
        mem_addr  = (state == ST_WRITE) ? cur_dst : cur_src;
        mem_size  = (state == ST_WRITE) ? beat_q : beat_rd;
        mem_wdata = data_q;
        busy      = (state != ST_IDLE);
        done_p    = (state == ST_DONE);
        perr_p    = (state == ST_ERROR) && prog_kind;
        xerr_p    = (state == ST_ERROR) && !prog_kind;
    end

    // Channel state machine with address and count tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            hs_q       <= 1'b0;
            hd_q       <= 1'b0;
            prog_kind  <= 1'b0;
            ssz_q      <= '0;
            dsz_q      <= '0;
            bw_q       <= '0;
            beat_q     <= '0;
            src_base_q <= '0;
            dst_base_q <= '0;
            cur_src    <= '0;
            cur_dst    <= '0;
            remain     <= '0;
            data_q     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start_p) begin
                    hs_q       <= mode.hold_src;
                    hd_q       <= mode.hold_dst;
                    ssz_q      <= mode.src_sz;
                    dsz_q      <= mode.dst_sz;
                    bw_q       <= mode.bw_sz;
                    src_base_q <= src;
                    dst_base_q <= dst;
                    cur_src    <= src;
                    cur_dst    <= dst;
                    remain     <= cnt;
                    prog_kind  <= prog_err;
                    state      <= prog_err ? ST_ERROR : ST_READ;
                end
                ST_READ: if (mem_ack) begin
                    if (mem_err) begin
                        state <= ST_ERROR;
                    end else begin
                        data_q <= mem_rdata;
                        beat_q <= beat_rd;
                        state  <= ST_WRITE;
                    end
                end
                ST_WRITE: if (mem_ack) begin
                    if (mem_err) begin
                        state <= ST_ERROR;
                    end else begin
                        if (!hs_q) cur_src <= cur_src + step_a;
                        if (!hd_q) cur_dst <= cur_dst + step_a;
                        remain <= remain - beat_bytes;
                        state  <= (remain == beat_bytes) ? ST_DONE : ST_READ;
                    end
                end
                ST_DONE:  state <= ST_IDLE;
                ST_ERROR: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // R12: request fields hold until acknowledged.
    a_r12_req_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

    // R3: held source reads stay on the programmed address and size.
    a_r3_src_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && hs_q) |-> (mem_addr == src_base_q && mem_size == ssz_q));

    // R4: held destination writes stay on the programmed address and size.
    a_r4_dst_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && hd_q) |-> (mem_addr == dst_base_q && mem_size == dsz_q));

    // R2: a read never asks for more than the bytes still owed.
    a_r2_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> (CNT_W'(sz_bytes(mem_size)) <= remain));

    // R5: a rejected start issues no request on the following cycle.
    a_r5_no_req_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start_p && prog_err) |=> !mem_req);

endmodule

// File: rtl/dma_hold_irq.sv
// Module dma_hold_irq
// Sticky status flags with write-one-to-clear, and the interrupt line.
// A flag that is set and cleared in the same cycle stays set.
module dma_hold_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       done_p,
    input  logic       perr_p,
    input  logic       xerr_p,
    input  logic [2:0] clr,
    input  logic       done_ie,
    input  logic       err_ie,
    output logic [2:0] flags_q,
    output logic       irq
);

    // Flag bits: 0 done, 1 programming error, 2 transfer error.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= {xerr_p, perr_p, done_p} | (flags_q & ~clr);
    end

    // Interrupt is any flag whose enable is set.
    always_comb irq = (flags_q[0] && done_ie) || ((flags_q[1] || flags_q[2]) && err_ie);

    // R9: completion always leaves the done flag set.
    a_r9_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
        done_p |=> flags_q[0]);

    // R11: a flag only drops after a clear.
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[1] && !clr[1]) |=> flags_q[1]);

endmodule

// File: rtl/dma_hold_chan.sv
// Module dma_hold_chan (top)
// Single-channel DMA with independent source/destination address hold.
// It connects the register block, the start-time check, the transfer
// engine and the status/interrupt block.
// Assumes reg_wdata is wide enough for ADDR_W and CNT_W (both at most 32),
// and CNT_W of at least 4.
module dma_hold_chan
    import dma_hold_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [63:0]       mem_wdata,
    input  logic [63:0]       mem_rdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    output logic              busy,
    output logic              stat_done,
    output logic              stat_perr,
    output logic              stat_xerr,
    output logic              irq
);

    localparam int DATA_W = 64;

    mode_t             mode_q;
    logic [ADDR_W-1:0] src_q, dst_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              start_p, prog_err, done_p, perr_p, xerr_p;
    logic [2:0]        stat_clr, flags;

    dma_hold_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .busy(busy), .mode_q(mode_q), .src_q(src_q),
        .dst_q(dst_q), .cnt_q(cnt_q), .start_p(start_p), .stat_clr(stat_clr)
    );

    dma_hold_check #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_check (
        .mode(mode_q), .src(src_q), .dst(dst_q), .cnt(cnt_q), .prog_err(prog_err)
    );

    dma_hold_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .mode(mode_q), .src(src_q), .dst(dst_q),
        .cnt(cnt_q), .start_p(start_p), .prog_err(prog_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .mem_err(mem_err), .busy(busy),
        .done_p(done_p), .perr_p(perr_p), .xerr_p(xerr_p)
    );

    dma_hold_irq u_irq (
        .clk(clk), .rst_n(rst_n), .done_p(done_p), .perr_p(perr_p),
        .xerr_p(xerr_p), .clr(stat_clr), .done_ie(mode_q.done_ie),
        .err_ie(mode_q.err_ie), .flags_q(flags), .irq(irq)
    );

    assign stat_done = flags[0];
    assign stat_perr = flags[1];
    assign stat_xerr = flags[2];

    // R10: an error flag never appears together with a fresh done flag.
    a_r10_err_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        xerr_p |-> !done_p);

endmodule

// File: tb/dma_hold_chan_test.sv
`timescale 1ns/1ps
module dma_hold_chan_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [1:0]  mem_size;
    logic [63:0] mem_wdata;
    logic [63:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;
    logic        busy, stat_done, stat_perr, stat_xerr, irq;

    dma_hold_chan #(.ADDR_W(16), .CNT_W(10)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .busy(busy), .stat_done(stat_done), .stat_perr(stat_perr),
        .stat_xerr(stat_xerr), .irq(irq)
    );

    always #10 clk = ~clk;

    int total = 0, bad = 0, cyc = 0;
    int lat = 0, wcnt = 0, err_at = -1, acc_n = 0, nrd = 0, nwr = 0, ex_n = 0;
    logic [7:0] mem [256];
    logic [7:0] init_m [256];
    logic [7:0] expm [256];
    int rd_a [256], rd_s [256], wr_a [256], wr_s [256];
    int ex_rd_a [256], ex_wr_a [256], ex_s [256];

    // Watchdog: an expired run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Byte memory model with programmable delay and error injection.
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
            mem_err = 1'b0;
        end else if (mem_req) begin
            if (wcnt < lat) wcnt++;
            else begin
                wcnt = 0;
                mem_ack = 1'b1;
                mem_err = (acc_n == err_at);
                if (mem_we) begin
                    if (nwr < 256) begin wr_a[nwr] = int'(mem_addr); wr_s[nwr] = int'(mem_size); end
                    nwr++;
                    if (!mem_err)
                        for (int k = 0; k < (1 << mem_size); k++)
                            mem[(int'(mem_addr) + k) & 255] = mem_wdata[8*k +: 8];
                end else begin
                    if (nrd < 256) begin rd_a[nrd] = int'(mem_addr); rd_s[nrd] = int'(mem_size); end
                    nrd++;
                    mem_rdata = '0;
                    for (int k = 0; k < (1 << mem_size); k++)
                        mem_rdata[8*k +: 8] = mem[(int'(mem_addr) + k) & 255];
                end
                acc_n++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int mode_w(int st, int hs, int hd, int ss, int ds, int bw,
                                  int swe, int sel, int die, int eie);
        return st | (hs << 1) | (hd << 2) | (ss << 3) | (ds << 5) | (bw << 7) |
               (swe << 9) | (sel << 10) | (die << 11) | (eie << 12);
    endfunction

    function automatic int fit(int rem, int bw);
        int c;
        c = (rem >= 8) ? 3 : (rem >= 4) ? 2 : (rem >= 2) ? 1 : 0;
        return (c < bw) ? c : bw;
    endfunction

    task automatic wr_reg(input int a, input int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a[2:0]; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while (busy && n < 5000) begin @(negedge clk); n++; end
    endtask

    task automatic prep(input int seed);
        wr_reg(1, 7);
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i * 37 + seed);
            init_m[i] = mem[i];
        end
        acc_n = 0; nrd = 0; nwr = 0; err_at = -1; wcnt = 0;
    endtask

    task automatic build_exp(input int src, input int dst, input int cnt, input int hs,
                             input int hd, input int ss, input int ds, input int bw);
        int rem, s, d, b;
        rem = cnt; s = src; d = dst; ex_n = 0;
        for (int i = 0; i < 256; i++) expm[i] = init_m[i];
        while (rem > 0 && ex_n < 256) begin
            b = hs ? ss : hd ? ds : fit(rem, bw);
            ex_rd_a[ex_n] = s; ex_wr_a[ex_n] = d; ex_s[ex_n] = b;
            for (int k = 0; k < (1 << b); k++) expm[(d + k) & 255] = init_m[(s + k) & 255];
            if (!hs) s += (1 << b);
            if (!hd) d += (1 << b);
            rem -= (1 << b);
            ex_n++;
        end
    endtask

    task automatic check_seq(input string req);
        int mis = 0;
        chk(nrd == ex_n, req, "read count", nrd, ex_n);
        chk(nwr == ex_n, req, "write count", nwr, ex_n);
        for (int i = 0; i < ex_n && i < nrd && i < nwr; i++)
            if (rd_a[i] != ex_rd_a[i] || wr_a[i] != ex_wr_a[i] ||
                rd_s[i] != ex_s[i] || wr_s[i] != ex_s[i]) mis++;
        chk(mis == 0, req, "beat address/size mismatches", mis, 0);
        mis = 0;
        for (int i = 0; i < 256; i++) if (mem[i] != expm[i]) mis++;
        chk(mis == 0, req, "memory byte mismatches", mis, 0);
    endtask

    task automatic xfer(input int src, input int dst, input int cnt, input int hs, input int hd,
                        input int ss, input int ds, input int bw, input int die, input string req);
        prep(cnt + src);
        build_exp(src, dst, cnt, hs, hd, ss, ds, bw);
        wr_reg(0, mode_w(0, hs, hd, ss, ds, bw, 0, 0, die, 0));
        wr_reg(2, src); wr_reg(3, dst); wr_reg(4, cnt);
        wr_reg(0, mode_w(1, hs, hd, ss, ds, bw, 0, 0, die, 0));
        wait_idle();
        check_seq(req);
        chk(stat_done == 1'b1, req, "done flag", int'(stat_done), 1);
    endtask

    task automatic perr(input int src, input int dst, input int cnt, input int hs, input int hd,
                        input int ss, input int ds, input int bw, input string req);
        prep(5);
        wr_reg(0, mode_w(0, hs, hd, ss, ds, bw, 0, 0, 0, 1));
        wr_reg(2, src); wr_reg(3, dst); wr_reg(4, cnt);
        wr_reg(0, mode_w(1, hs, hd, ss, ds, bw, 0, 0, 0, 1));
        wait_idle();
        chk(stat_perr == 1'b1, req, "programming error flag", int'(stat_perr), 1);
        chk(acc_n == 0, req, "memory accesses on rejected start", acc_n, 0);
        chk(stat_done == 1'b0, req, "done after rejected start", int'(stat_done), 0);
        chk(irq == 1'b1, req, "irq with error enable", int'(irq), 1);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!busy && !mem_req, "R1", "busy|req in reset", int'(busy | mem_req), 0);
        chk({stat_done, stat_perr, stat_xerr, irq} == 4'b0, "R1", "flags/irq in reset",
            int'({stat_done, stat_perr, stat_xerr, irq}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: no hold, every bandwidth size, counts 1..19, with a varied delay
        for (int bw = 0; bw < 4; bw++)
            for (int c = 1; c < 20; c++) begin
                lat = c % 3;
                xfer(16 + (c % 5), 144 + (c % 3), c, 0, 0, 0, 0, bw, 0, "R2");
            end
        lat = 0;

        // R3: source hold, each size, several multiples
        for (int s = 0; s < 4; s++)
            for (int n = 1; n < 5; n++)
                xfer(32, 136 + n, n << s, 1, 0, s, 0, 3, 0, "R3");

        // R4: destination hold, each size
        for (int s = 0; s < 4; s++)
            for (int n = 1; n < 5; n++)
                xfer(8 + n, 160, n << s, 0, 1, 0, s, 3, 0, "R4");

        // R3/R4: both sides held with equal size
        xfer(40, 192, 24, 1, 1, 3, 3, 3, 0, "R4");

        // R5: zero count, count not a multiple, unaligned held addresses
        perr(16, 144, 0, 0, 0, 0, 0, 3, "R5");
        perr(32, 144, 6, 1, 0, 2, 0, 3, "R5");
        perr(33, 144, 8, 1, 0, 1, 0, 3, "R5");
        perr(16, 146, 8, 0, 1, 0, 2, 3, "R5");
        // R6: hold size above bandwidth, and mismatched hold sizes
        perr(32, 144, 16, 1, 0, 3, 0, 2, "R6");
        perr(32, 160, 8, 1, 1, 0, 1, 3, "R6");

        // R11: clear the programming-error flag by writing 1 to bit 1
        wr_reg(1, 2);
        chk(stat_perr == 1'b0, "R11", "perr after clear", int'(stat_perr), 0);
        chk(irq == 1'b0, "R11", "irq after clear", int'(irq), 0);

        // R9: done with and without the done interrupt enable
        xfer(16, 144, 12, 0, 0, 0, 0, 3, 1, "R9");
        chk(irq == 1'b1, "R9", "irq with done enable", int'(irq), 1);
        repeat (4) @(negedge clk);
        chk(irq == 1'b1, "R11", "irq held until cleared", int'(irq), 1);
        wr_reg(1, 1);
        chk(stat_done == 1'b0 && irq == 1'b0, "R11", "done/irq after clear",
            int'({stat_done, irq}), 0);
        xfer(16, 144, 12, 0, 0, 0, 0, 3, 0, "R9");
        chk(irq == 1'b0, "R9", "irq without done enable", int'(irq), 0);

        // R10: error response on the third access stops the job
        prep(9);
        err_at = 2;
        wr_reg(0, mode_w(0, 0, 0, 0, 0, 0, 0, 0, 1, 1));
        wr_reg(2, 16); wr_reg(3, 144); wr_reg(4, 8);
        wr_reg(0, mode_w(1, 0, 0, 0, 0, 0, 0, 0, 1, 1));
        wait_idle();
        chk(stat_xerr == 1'b1, "R10", "transfer error flag", int'(stat_xerr), 1);
        chk(stat_done == 1'b0, "R10", "done after error", int'(stat_done), 0);
        chk(acc_n == 3, "R10", "accesses before stop", acc_n, 3);
        chk(irq == 1'b1, "R10", "irq with error enable", int'(irq), 1);
        wr_reg(1, 4);
        chk(stat_xerr == 1'b0, "R11", "xerr after clear", int'(stat_xerr), 0);
        // R10: error recorded but no irq with enable clear
        prep(9);
        err_at = 0;
        wr_reg(0, mode_w(1, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        wait_idle();
        chk(stat_xerr == 1'b1 && irq == 1'b0, "R10", "error recorded without irq",
            int'({stat_xerr, irq}), 2);

        // R8: source-register start
        prep(3);
        build_exp(20, 150, 10, 0, 0, 0, 0, 2);
        wr_reg(0, mode_w(0, 0, 0, 0, 0, 2, 1, 1, 0, 0));
        wr_reg(4, 10); wr_reg(3, 150);
        repeat (4) @(negedge clk);
        chk(acc_n == 0 && !busy, "R8", "destination write must not start", acc_n, 0);
        wr_reg(2, 20);
        wait_idle();
        check_seq("R8");
        // R8: destination-register start
        prep(4);
        build_exp(24, 170, 9, 0, 0, 0, 0, 3);
        wr_reg(0, mode_w(0, 0, 0, 0, 0, 3, 1, 0, 0, 0));
        wr_reg(4, 9); wr_reg(2, 24);
        repeat (4) @(negedge clk);
        chk(acc_n == 0 && !busy, "R8", "source write must not start", acc_n, 0);
        wr_reg(3, 170);
        wait_idle();
        check_seq("R8");
        // R8: single-write disabled
        prep(6);
        wr_reg(0, mode_w(0, 0, 0, 0, 0, 3, 0, 1, 0, 0));
        wr_reg(2, 24); wr_reg(3, 170);
        repeat (6) @(negedge clk);
        chk(acc_n == 0 && !busy && !stat_done, "R8", "no start with mode bit 9 clear", acc_n, 0);

        // R7: writes during a job are ignored
        lat = 2;
        prep(11);
        build_exp(16, 144, 16, 0, 0, 0, 0, 0);
        wr_reg(0, mode_w(0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        wr_reg(2, 16); wr_reg(3, 144); wr_reg(4, 16);
        wr_reg(0, mode_w(1, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        repeat (6) @(negedge clk);
        chk(busy == 1'b1, "R7", "busy after start bit", int'(busy), 1);
        wr_reg(4, 3);
        wr_reg(2, 80);
        wr_reg(0, mode_w(1, 0, 0, 0, 0, 3, 0, 0, 0, 0));
        wait_idle();
        repeat (6) @(negedge clk);
        chk(!busy, "R7", "no second job", int'(busy), 0);
        check_seq("R7");
        lat = 0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule